// File: doc/BRIEF.md
# Low-Power Infrared Reference Tick Generator

This block produces the timing reference that a serial infrared receiver uses when it checks the minimum width of incoming pulses. Software programs a 16-bit divisor through two byte-wide registers on a simple register bus. The block then emits a one-cycle enable pulse every `divisor` serial clock cycles. That pulse rate is sixteen times the low-power baud rate, so the baud rate is the serial clock frequency divided by 16 times the divisor.

Register access is gated by a latch-access input. This input is bit 7 of the line control register elsewhere in the UART. While it is low, writes are dropped and reads return zero. A divisor of zero turns the reference off and lowers the detection-enable output, which stops all pulse detection in the receiver.

Writing the high byte starts a settle window of eight cycles. During that window a busy flag is high and no ticks are issued. Any accepted write restarts the tick phase, so the first tick after reprogramming arrives a whole divisor period after the window closes.

Top module: `irlp_tick_gen`

## Requirements
- R1: After reset both divisor bytes read as 0, and `tick_o`, `det_en_o` and `busy_o` are all low.
- R2: With a nonzero divisor N and `busy_o` low, `tick_o` is high for exactly one cycle out of every N cycles.
- R3: A write while `dlab_i` is 0 has no effect: the register keeps its value and no settle window starts.
- R4: Reads are combinational. With `dlab_i`=1 and `rd_i`=1, `rdata_o` returns the low byte when `sel_i`=0 and the high byte (divisor bits 15:8) when `sel_i`=1. With `dlab_i`=0, `rdata_o` is 0.
- R5: When the divisor is 0, `tick_o` and `det_en_o` stay low. When the divisor is nonzero, `det_en_o` is high.
- R6: An accepted high-byte write raises `busy_o` in the next cycle for exactly 8 cycles, and `tick_o` stays low during that time.
- R7: After any accepted write, the tick phase restarts. The first tick falls in the N-th cycle with `busy_o` low that follows the write edge.
- R8: A divisor of 1 gives a tick in every cycle in which `busy_o` is low.
- R9: An accepted low-byte write does not start a settle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dlab_i | input | 1 | Latch-access enable; register access is allowed only when high |
| sel_i | input | 1 | Register select: 0 selects the low byte, 1 selects the high byte |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| tick_o | output | 1 | One-cycle enable pulse at sixteen times the low-power baud rate |
| det_en_o | output | 1 | High while the divisor is nonzero |
| busy_o | output | 1 | Settle window active after a high-byte write |

## Verification
The assertions assume that strobes are clean, single-cycle values sampled at the rising edge. They also assume that the divisor changes only through accepted writes, so any cycle without a write leaves the tick spacing fixed. The stimulus drives every input on the falling edge, and it holds each write strobe for one cycle only. Before the next reprogramming step starts, the stimulus waits until the expected-tick queue is empty, so each tick window is judged against a single, stable divisor.

// File: rtl/irlp_pkg.sv
package irlp_pkg;
    parameter int unsigned BYTE_W = 8;
    parameter int unsigned SETTLE_CYCLES = 8;
    localparam int unsigned DIV_W = 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
    } div_regs_t;
endpackage

// File: rtl/irlp_div_regs.sv
module irlp_div_regs
    import irlp_pkg::*;
#(
    parameter int unsigned BW = BYTE_W
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            dlab_i,
    input  logic            sel_i,
    input  logic            wr_i,
    input  logic            rd_i,
    input  logic [BW-1:0]   wdata_i,
    output logic [BW-1:0]   rdata_o,
    output logic [2*BW-1:0] div_o,
    output logic            lo_wr_o,
    output logic            hi_wr_o
);
    typedef struct packed {
        logic [BW-1:0] lo;
        logic [BW-1:0] hi;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  wr_ok;

    always_comb begin
        regs_d  = regs_q;
        wr_ok   = wr_i & dlab_i;
        lo_wr_o = wr_ok & ~sel_i;
        hi_wr_o = wr_ok & sel_i;
        if (lo_wr_o) regs_d.lo = wdata_i;
        if (hi_wr_o) regs_d.hi = wdata_i;
        rdata_o = '0;
        if (rd_i && dlab_i) rdata_o = sel_i ? regs_q.hi : regs_q.lo;
        div_o = {regs_q.hi, regs_q.lo};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    p_locked_no_change_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dlab_i |=> $stable(div_o));
    p_locked_read_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dlab_i && rd_i) |-> (rdata_o == '0));
endmodule

// File: rtl/irlp_settle_timer.sv
module irlp_settle_timer #(
    parameter int unsigned CYCLES = irlp_pkg::SETTLE_CYCLES
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic busy_o
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i)              st_d.cnt = CW'(CYCLES);
        else if (st_q.cnt != '0)  st_d.cnt = st_q.cnt - 1'b1;
        busy_o = (st_q.cnt != '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    p_busy_after_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> busy_o);
    p_busy_needs_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!start_i && !busy_o) |=> !busy_o);
endmodule

// File: rtl/irlp_tick_counter.sv
module irlp_tick_counter #(
    parameter int unsigned DW = irlp_pkg::DIV_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [DW-1:0] div_i,
    input  logic          load_i,
    input  logic          hold_i,
    output logic          tick_o
);
    typedef struct packed {
        logic [DW-1:0] cnt;
    } tc_t;

    tc_t  tc_d, tc_q;
    logic off;
    logic last;

    always_comb begin
        tc_d   = tc_q;
        off    = (div_i == '0);
        last   = (tc_q.cnt >= div_i - 1'b1);
        tick_o = ~off & ~hold_i & last;
        if (load_i || hold_i || off) tc_d.cnt = '0;
        else if (last)               tc_d.cnt = '0;
        else                         tc_d.cnt = tc_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tc_q <= '0;
        else         tc_q <= tc_d;
    end

    p_zero_no_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_i == '0) |-> !tick_o);
    p_hold_no_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_i |-> !tick_o);
    p_tick_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && !load_i) |=> (!tick_o || div_i == 1));
endmodule

// File: rtl/irlp_tick_gen.sv
module irlp_tick_gen
    import irlp_pkg::*;
#(
    parameter int unsigned BW     = BYTE_W,
    parameter int unsigned SETTLE = SETTLE_CYCLES
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          dlab_i,
    input  logic          sel_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [BW-1:0] wdata_i,
    output logic [BW-1:0] rdata_o,
    output logic          tick_o,
    output logic          det_en_o,
    output logic          busy_o
);
    localparam int unsigned DW = 2 * BW;

    logic [DW-1:0] div;
    logic          lo_wr;
    logic          hi_wr;

    irlp_div_regs #(.BW(BW)) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni), .dlab_i(dlab_i), .sel_i(sel_i),
        .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .div_o(div), .lo_wr_o(lo_wr), .hi_wr_o(hi_wr)
    );

    irlp_settle_timer #(.CYCLES(SETTLE)) u_settle (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(hi_wr), .busy_o(busy_o)
    );

    irlp_tick_counter #(.DW(DW)) u_cnt (
        .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div), .load_i(lo_wr | hi_wr),
        .hold_i(busy_o), .tick_o(tick_o)
    );

    assign det_en_o = (div != '0);

    p_det_off_no_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !det_en_o |-> !tick_o);
    p_low_write_no_settle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && dlab_i && !sel_i && !busy_o) |=> !busy_o);
endmodule

// File: tb/irlp_tick_gen_bench.sv
module irlp_tick_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       dlab = 1'b0;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tick;
    logic       det_en;
    logic       busy;

    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        logic  tick;
        logic  busy;
        string req;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irlp_tick_gen u_irlp_tick_gen (
        .clk_i(clk), .rst_ni(rst_ni), .dlab_i(dlab), .sel_i(sel), .wr_i(wr),
        .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .tick_o(tick),
        .det_en_o(det_en), .busy_o(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: pop one expected item per falling edge
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(tick === e.tick, {e.req, " tick"}, int'(tick), int'(e.tick));
            check(busy === e.busy, {e.req, " busy"}, int'(busy), int'(e.busy));
        end
    end

    task automatic wr_reg(input logic s, input logic [7:0] d);
        @(negedge clk);
        sel = s; wdata = d; wr = 1'b1;
        @(posedge clk);
        #1 wr = 1'b0;
    endtask

    task automatic rd_reg(input logic s, input logic [7:0] expv, input string req);
        @(negedge clk);
        sel = s; rd = 1'b1;
        #1 check(rdata === expv, req, int'(rdata), int'(expv));
        rd = 1'b0;
    endtask

    task automatic push_run(input int n, input int cycles, input string req);
        for (int k = 1; k <= cycles; k++) begin
            exp_t e;
            e.tick = (n != 0) && (k % n == 0);
            e.busy = 1'b0;
            e.req  = req;
            exp_q.push_back(e);
        end
    endtask

    task automatic push_settle(input int n, input int cycles, input string req);
        for (int k = 0; k < 8; k++) begin
            exp_t e;
            e.tick = 1'b0; e.busy = 1'b1; e.req = "R6";
            exp_q.push_back(e);
        end
        push_run(n, cycles, req);
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        @(posedge clk);
    endtask

    task automatic set_div(input int n, input int cycles, input string req);
        wr_reg(1'b0, n[7:0]);
        wr_reg(1'b1, n[15:8]);
        push_settle(n, cycles, req);
        drain();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tick === 1'b0, "R1 tick", int'(tick), 0);
        check(det_en === 1'b0, "R1 det_en", int'(det_en), 0);
        check(busy === 1'b0, "R1 busy", int'(busy), 0);
        dlab = 1'b1;
        rd_reg(1'b0, 8'h00, "R1 lo");
        rd_reg(1'b1, 8'h00, "R1 hi");
        // R5 zero divisor: no ticks
        push_run(0, 20, "R5");
        drain();
        check(det_en === 1'b0, "R5 det_en off", int'(det_en), 0);
        // R2 R6 R7 divisor 5
        set_div(5, 30, "R2");
        check(det_en === 1'b1, "R5 det_en on", int'(det_en), 1);
        rd_reg(1'b0, 8'd5, "R4 lo read");
        rd_reg(1'b1, 8'd0, "R4 hi read");
        dlab = 1'b0;
        rd_reg(1'b0, 8'd0, "R4 locked read");
        // R3 locked writes ignored
        wr_reg(1'b0, 8'd9);
        wr_reg(1'b1, 8'd7);
        @(negedge clk);
        check(busy === 1'b0, "R3 no settle", int'(busy), 0);
        dlab = 1'b1;
        rd_reg(1'b0, 8'd5, "R3 lo kept");
        rd_reg(1'b1, 8'd0, "R3 hi kept");
        // R8 divisor 1
        set_div(1, 20, "R8");
        // R9 R7 low-only write, no settle
        wr_reg(1'b0, 8'd3);
        push_run(3, 15, "R9");
        drain();
        // R7 R2 divisor using high byte: 256
        set_div(256, 600, "R7");
        rd_reg(1'b1, 8'd1, "R4 hi field");
        // R5 back to zero
        set_div(0, 40, "R5");
        check(det_en === 1'b0, "R5 det_en off again", int'(det_en), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule